// File: doc/BRIEF.md
# Parallel Flash Program/Erase Sequencer

This block drives a byte-wide parallel flash device for a host that only wants to say "program this byte", "erase this sector" or "erase the whole array". The host pulses a start strobe with an operation code, an address and a data byte. The sequencer then writes the unlock and command cycles on the flash bus, using strobe timing set by parameters. It polls the device status until the embedded algorithm settles and reads the target location back to confirm the result. It finishes with a one-clock done pulse that carries a pass/fail flag and an error code.

Completion is found by comparing status bit 6 across consecutive status reads. No fixed delay is used. A device that raises its time-limit flag (status bit 5) while still toggling gets two more reads. If it is still toggling after them, the operation fails. A poll budget counted in reads guards against a device that never settles. Either failure ends with a reset command write, so the device returns to array-read mode.

Top module: `nvm_cmd_sequencer`

## Requirements
- R1: Operation code 00 (byte program) writes exactly four cycles, in this order: AAh at 555h, 55h at 2AAh, A0h at 555h, then the request data at the request address.
- R2: Operation code 01 (sector erase) writes six cycles: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 30h at the request address. The device decodes the sector from the upper address bits.
- R3: Operation code 10 (chip erase) writes the same first five cycles as R2, followed by 10h at 555h.
- R4: On every write cycle, chip enable is low and the address and data are driven and held constant. Setup lasts T_SETUP clocks before the write strobe falls. The strobe stays low for exactly T_PULSE clocks. Hold lasts T_HOLD clocks after the strobe rises. Write strobe and output enable are never low together. Data is never driven while output enable is low. All strobes are high and data is not driven during reset.
- R5: After the command cycles, the sequencer reads status at the request address. It treats the operation as finished as soon as bit 6 of two consecutive status reads is equal. A device that is already settled takes exactly two status reads.
- R6: After a finished program, one more read at the target address is compared with the request data. A mismatch ends the operation with error code 1.
- R7: After a finished erase, one more read at the request address must return FFh. Any other value ends the operation with error code 1.
- R8: If bit 6 differs and bit 5 is 1, the sequencer makes two further status reads. If their bit 6 values still differ, it stops with error code 2 and writes F0h at address 0. If they agree, the operation continues normally.
- R9: If MAX_POLLS status reads pass without completion, the sequencer stops with error code 3 and writes F0h at address 0.
- R10: Busy rises in the clock after a start is accepted while idle. A start raised while busy is ignored: it causes no bus cycle and no done pulse.
- R11: Done is high for exactly one clock, in the first clock in which busy is low again. The error flag is 1 exactly when the error code is non-zero. The code is 0 on success.
- R12: Operation code 11 writes a single F0h at address 0 and completes without error and without polling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_start | input | 1 | Start strobe, accepted while idle |
| req_op | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 device reset |
| req_addr | input | AW | Target byte address (sector address for erase) |
| req_data | input | 8 | Byte to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Failure flag, valid with done |
| err_code | output | 2 | 0 ok, 1 verify mismatch, 2 device time limit, 3 poll budget spent |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_addr | output | AW | Flash address |
| fl_dq_out | output | 8 | Data driven toward the flash |
| fl_dq_oe | output | 1 | Enable for fl_dq_out on the shared data lines |
| fl_dq_in | input | 8 | Data returned by the flash |

## Verification
The hardest case to reach is a device that raises its time-limit bit while still toggling. That case has two outcomes, depending on whether the two extra reads agree. A plain flash model never produces it. The bench flash model therefore has injectable status behaviours: an endless toggle with bit 5 set, an endless toggle with bit 5 clear, and a finite busy period reported with bit 5 set. It also has an erase that silently does nothing. The number of status reads and the trailing reset write are checked at the bus for each of these cases. The bench also programs ones over zeros, both directed and at random against a mirror memory, to provoke verify mismatches.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2,
    OP_RST  = 2'd3
  } nvm_op_e;

  typedef enum logic [1:0] {
    EC_NONE   = 2'd0,
    EC_VERIFY = 2'd1,
    EC_DEVICE = 2'd2,
    EC_WDOG   = 2'd3
  } nvm_err_e;

  typedef enum logic [1:0] {
    PV_MORE = 2'd0,
    PV_DONE = 2'd1,
    PV_DEV  = 2'd2,
    PV_WDOG = 2'd3
  } poll_verdict_e;

  // Width of the fixed unlock addresses.
  localparam int unsigned CMD_AW = 11;

  // One command write: fixed address/data, or the request's own.
  typedef struct packed {
    logic [CMD_AW-1:0] addr;
    logic [7:0]        data;
    logic              use_req_addr;
    logic              use_req_data;
  } cmd_beat_t;

endpackage

// File: rtl/nvm_cmd_table.sv
module nvm_cmd_table
  import nvm_seq_pkg::*;
(
  input  nvm_op_e    op,
  input  logic [2:0] idx,
  output cmd_beat_t  beat,
  output logic       last
);

  always_comb begin
    beat.addr         = '0;
    beat.data         = 8'h00;
    beat.use_req_addr = 1'b0;
    beat.use_req_data = 1'b0;
    last              = 1'b0;
    if (op == OP_RST) begin
      beat.addr = '0;
      beat.data = 8'hF0;
      last      = 1'b1;
    end else begin
      case (idx)
        3'd0, 3'd3: begin
          if (idx == 3'd3 && op == OP_PROG) begin
            beat.use_req_addr = 1'b1;
            beat.use_req_data = 1'b1;
            last              = 1'b1;
          end else begin
            beat.addr = CMD_AW'(11'h555);
            beat.data = 8'hAA;
          end
        end
        3'd1, 3'd4: begin
          beat.addr = CMD_AW'(11'h2AA);
          beat.data = 8'h55;
        end
        3'd2: begin
          beat.addr = CMD_AW'(11'h555);
          beat.data = (op == OP_PROG) ? 8'hA0 : 8'h80;
        end
        3'd5: begin
          last = 1'b1;
          if (op == OP_SECT) begin
            beat.use_req_addr = 1'b1;
            beat.data         = 8'h30;
          end else begin
            beat.addr = CMD_AW'(11'h555);
            beat.data = 8'h10;
          end
        end
        default: begin
          beat.addr = '0;
          beat.data = 8'hF0;
          last      = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/nvm_bus_cycle.sv
module nvm_bus_cycle #(
  parameter int unsigned AW      = 19,
  parameter int unsigned T_SETUP = 1,
  parameter int unsigned T_PULSE = 2,
  parameter int unsigned T_HOLD  = 1,
  parameter int unsigned T_READ  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic [7:0]    dq_in,
  output logic          done,
  output logic [7:0]    rdata,
  output logic          ce_n,
  output logic          we_n,
  output logic          oe_n,
  output logic          dq_oe,
  output logic [AW-1:0] a_out,
  output logic [7:0]    d_out
);

  localparam int unsigned T_W   = (T_SETUP > T_PULSE) ? T_SETUP : T_PULSE;
  localparam int unsigned T_WR  = (T_W > T_HOLD) ? T_W : T_HOLD;
  localparam int unsigned T_MAX = (T_WR > T_READ) ? T_WR : T_READ;
  localparam int unsigned CW    = (T_MAX > 1) ? $clog2(T_MAX) : 1;

  typedef enum logic [2:0] {
    BC_IDLE, BC_SETUP, BC_PULSE, BC_HOLD, BC_READ
  } bc_state_e;

  bc_state_e      st_q, st_n;
  logic [CW-1:0]  cnt_q, cnt_n;
  logic           ld, cap, fin;
  logic           ce_n_q, we_n_q, oe_n_q, dq_oe_q, done_q;
  logic [AW-1:0]  addr_q;
  logic [7:0]     data_q, rdata_q;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    ld    = 1'b0;
    cap   = 1'b0;
    fin   = 1'b0;
    case (st_q)
      BC_IDLE: begin
        if (go) begin
          ld = 1'b1;
          if (wr) begin
            st_n  = BC_SETUP;
            cnt_n = CW'(T_SETUP - 1);
          end else begin
            st_n  = BC_READ;
            cnt_n = CW'(T_READ - 1);
          end
        end
      end
      BC_SETUP: begin
        if (cnt_q == '0) begin
          st_n  = BC_PULSE;
          cnt_n = CW'(T_PULSE - 1);
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      BC_PULSE: begin
        if (cnt_q == '0) begin
          st_n  = BC_HOLD;
          cnt_n = CW'(T_HOLD - 1);
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      BC_HOLD: begin
        if (cnt_q == '0) begin
          st_n = BC_IDLE;
          fin  = 1'b1;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      BC_READ: begin
        if (cnt_q == '0) begin
          st_n = BC_IDLE;
          fin  = 1'b1;
          cap  = 1'b1;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      default: st_n = BC_IDLE;
    endcase
  end

  // Pins are registered from the next state so they track it with no lag.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= BC_IDLE;
      cnt_q   <= '0;
      ce_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      ce_n_q  <= (st_n == BC_IDLE);
      we_n_q  <= (st_n != BC_PULSE);
      oe_n_q  <= (st_n != BC_READ);
      dq_oe_q <= (st_n == BC_SETUP) || (st_n == BC_PULSE) || (st_n == BC_HOLD);
      done_q  <= fin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (ld) begin
      addr_q <= addr;
      data_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (cap) begin
      rdata_q <= dq_in;
    end
  end

  assign done  = done_q;
  assign rdata = rdata_q;
  assign ce_n  = ce_n_q;
  assign we_n  = we_n_q;
  assign oe_n  = oe_n_q;
  assign dq_oe = dq_oe_q;
  assign a_out = addr_q;
  assign d_out = data_q;

endmodule

// File: rtl/nvm_poll_judge.sv
module nvm_poll_judge
  import nvm_seq_pkg::*;
#(
  parameter int unsigned MAX_POLLS = 65536
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          rd_valid,
  input  logic [7:0]    rd_byte,
  output poll_verdict_e verdict
);

  localparam int unsigned CW = $clog2(MAX_POLLS + 1);

  logic          have_q, have_n;
  logic          prev_q, prev_n;
  logic          lc_q, lc_n;
  logic [CW-1:0] cnt_q, cnt_inc;
  logic          limit;

  assign cnt_inc = cnt_q + 1'b1;
  assign limit   = (cnt_inc >= CW'(MAX_POLLS));

  always_comb begin
    verdict = PV_MORE;
    have_n  = have_q;
    prev_n  = prev_q;
    lc_n    = lc_q;
    if (!have_q) begin
      have_n = 1'b1;
      prev_n = rd_byte[6];
      if (limit && !lc_q) verdict = PV_WDOG;
    end else if (rd_byte[6] == prev_q) begin
      verdict = PV_DONE;
    end else if (lc_q) begin
      verdict = PV_DEV;
    end else if (rd_byte[5]) begin
      lc_n   = 1'b1;
      have_n = 1'b0;
    end else if (limit) begin
      verdict = PV_WDOG;
    end else begin
      prev_n = rd_byte[6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      prev_q <= 1'b0;
      lc_q   <= 1'b0;
      cnt_q  <= '0;
    end else if (clr) begin
      have_q <= 1'b0;
      prev_q <= 1'b0;
      lc_q   <= 1'b0;
      cnt_q  <= '0;
    end else if (rd_valid) begin
      have_q <= have_n;
      prev_q <= prev_n;
      lc_q   <= lc_n;
      cnt_q  <= cnt_inc;
    end
  end

endmodule

// File: rtl/nvm_cmd_sequencer.sv
module nvm_cmd_sequencer
  import nvm_seq_pkg::*;
#(
  parameter int unsigned AW        = 19,
  parameter int unsigned T_SETUP   = 1,
  parameter int unsigned T_PULSE   = 2,
  parameter int unsigned T_HOLD    = 1,
  parameter int unsigned T_READ    = 2,
  parameter int unsigned MAX_POLLS = 65536
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_start,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [1:0]    err_code,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [7:0]    fl_dq_in
);

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_CMD, SQ_POLL, SQ_VERIFY, SQ_ABORT
  } sq_state_e;

  logic rst_meta_q, rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q_n    <= rst_meta_q;
    end
  end

  sq_state_e     st_q, st_n;
  nvm_op_e       op_q, rom_op;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [2:0]    idx_q, idx_n;
  logic          infl_q, infl_n;
  nvm_err_e      pend_q, pend_n;
  nvm_err_e      code_q, code_n, fin_code;
  logic          done_q, done_n, err_q, err_n;
  logic          cap, fin;

  cmd_beat_t     beat;
  logic          beat_last;
  logic          go, wr, bus_done;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata, bus_rdata, expect_byte;
  logic          poll_clr, poll_valid;
  poll_verdict_e verdict;

  assign rom_op = (st_q == SQ_ABORT) ? OP_RST : op_q;

  nvm_cmd_table u_table (
    .op   (rom_op),
    .idx  (idx_q),
    .beat (beat),
    .last (beat_last)
  );

  assign wr       = (st_q == SQ_CMD) || (st_q == SQ_ABORT);
  assign go       = (st_q != SQ_IDLE) && !infl_q;
  assign bus_addr = (wr && !beat.use_req_addr) ? AW'(beat.addr) : addr_q;
  assign bus_wdata = beat.use_req_data ? data_q : beat.data;

  nvm_bus_cycle #(
    .AW      (AW),
    .T_SETUP (T_SETUP),
    .T_PULSE (T_PULSE),
    .T_HOLD  (T_HOLD),
    .T_READ  (T_READ)
  ) u_bus (
    .clk   (clk),
    .rst_n (rst_q_n),
    .go    (go),
    .wr    (wr),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .dq_in (fl_dq_in),
    .done  (bus_done),
    .rdata (bus_rdata),
    .ce_n  (fl_ce_n),
    .we_n  (fl_we_n),
    .oe_n  (fl_oe_n),
    .dq_oe (fl_dq_oe),
    .a_out (fl_addr),
    .d_out (fl_dq_out)
  );

  assign poll_clr   = (st_q == SQ_CMD) && bus_done && beat_last;
  assign poll_valid = (st_q == SQ_POLL) && bus_done;

  nvm_poll_judge #(
    .MAX_POLLS (MAX_POLLS)
  ) u_judge (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .clr      (poll_clr),
    .rd_valid (poll_valid),
    .rd_byte  (bus_rdata),
    .verdict  (verdict)
  );

  assign expect_byte = (op_q == OP_PROG) ? data_q : 8'hFF;

  always_comb begin
    st_n     = st_q;
    idx_n    = idx_q;
    pend_n   = pend_q;
    done_n   = 1'b0;
    err_n    = err_q;
    code_n   = code_q;
    cap      = 1'b0;
    fin      = 1'b0;
    fin_code = EC_NONE;
    if (go)            infl_n = 1'b1;
    else if (bus_done) infl_n = 1'b0;
    else               infl_n = infl_q;
    case (st_q)
      SQ_IDLE: begin
        if (req_start) begin
          cap   = 1'b1;
          idx_n = '0;
          st_n  = SQ_CMD;
        end
      end
      SQ_CMD: begin
        if (bus_done) begin
          if (beat_last) begin
            idx_n = '0;
            if (op_q == OP_RST) fin = 1'b1;
            else                st_n = SQ_POLL;
          end else begin
            idx_n = idx_q + 1'b1;
          end
        end
      end
      SQ_POLL: begin
        if (bus_done) begin
          case (verdict)
            PV_DONE: st_n = SQ_VERIFY;
            PV_DEV: begin
              pend_n = EC_DEVICE;
              st_n   = SQ_ABORT;
            end
            PV_WDOG: begin
              pend_n = EC_WDOG;
              st_n   = SQ_ABORT;
            end
            default: st_n = SQ_POLL;
          endcase
        end
      end
      SQ_VERIFY: begin
        if (bus_done) begin
          fin      = 1'b1;
          fin_code = (bus_rdata == expect_byte) ? EC_NONE : EC_VERIFY;
        end
      end
      SQ_ABORT: begin
        if (bus_done) begin
          fin      = 1'b1;
          fin_code = pend_q;
        end
      end
      default: st_n = SQ_IDLE;
    endcase
    if (fin) begin
      st_n   = SQ_IDLE;
      done_n = 1'b1;
      err_n  = (fin_code != EC_NONE);
      code_n = fin_code;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      st_q   <= SQ_IDLE;
      idx_q  <= '0;
      infl_q <= 1'b0;
      pend_q <= EC_NONE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      code_q <= EC_NONE;
    end else begin
      st_q   <= st_n;
      idx_q  <= idx_n;
      infl_q <= infl_n;
      pend_q <= pend_n;
      done_q <= done_n;
      err_q  <= err_n;
      code_q <= code_n;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      op_q   <= OP_PROG;
      addr_q <= '0;
      data_q <= '0;
    end else if (cap) begin
      op_q   <= nvm_op_e'(req_op);
      addr_q <= req_addr;
      data_q <= req_data;
    end
  end

  assign busy     = (st_q != SQ_IDLE);
  assign done     = done_q;
  assign err      = err_q;
  assign err_code = code_q;

endmodule

// File: rtl/nvm_seq_checker.sv
module nvm_seq_checker #(
  parameter int unsigned AW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_start,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic [1:0]    err_code,
  input logic          fl_ce_n,
  input logic          fl_we_n,
  input logic          fl_oe_n,
  input logic [AW-1:0] fl_addr,
  input logic [7:0]    fl_dq_out,
  input logic          fl_dq_oe
);

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n));

  p_we_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> (fl_dq_oe && !fl_ce_n));

  p_read_undriven_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> !fl_dq_oe);

  p_write_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_dq_oe && $past(fl_dq_oe) && !fl_ce_n && !$past(fl_ce_n))
      |-> ($stable(fl_addr) && $stable(fl_dq_out)));

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_err_matches_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err == (err_code != 2'd0)));

  p_start_accepted_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_start && !busy) |=> busy);

  p_bus_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> (fl_ce_n && fl_we_n && fl_oe_n));

endmodule

bind nvm_cmd_sequencer nvm_seq_checker #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .req_start (req_start),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .err_code  (err_code),
  .fl_ce_n   (fl_ce_n),
  .fl_we_n   (fl_we_n),
  .fl_oe_n   (fl_oe_n),
  .fl_addr   (fl_addr),
  .fl_dq_out (fl_dq_out),
  .fl_dq_oe  (fl_dq_oe)
);

// File: tb/nvm_cmd_sequencer_tb.sv
module nvm_cmd_sequencer_tb;

  localparam int AW = 12;
  localparam int TS = 2;
  localparam int TP = 3;
  localparam int TH = 2;
  localparam int TR = 2;
  localparam int MP = 16;
  localparam int MEMN = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_start = 1'b0;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = 8'h00;
  logic          busy, done, err;
  logic [1:0]    err_code;
  logic          fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_dq_out;
  logic [7:0]    dq_in_r = 8'h00;

  always #4 clk = ~clk;

  nvm_cmd_sequencer #(
    .AW(AW), .T_SETUP(TS), .T_PULSE(TP), .T_HOLD(TH), .T_READ(TR), .MAX_POLLS(MP)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
    .err(err), .err_code(err_code), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n),
    .fl_oe_n(fl_oe_n), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out),
    .fl_dq_oe(fl_dq_oe), .fl_dq_in(dq_in_r)
  );

  int nchk = 0;
  int nerr = 0;

  // ---------------- flash model ----------------
  logic [7:0]    mem [MEMN];
  logic [7:0]    ref_mem [MEMN];
  logic [AW-1:0] wl_a [16];
  logic [7:0]    wl_d [16];
  int            wl_n = 0;
  int            rdcnt = 0;
  logic [47:0]   hist = '0;
  int            busy_left = 0;
  int            busy_len = 0;
  int            stuck_mode = 0;
  bit            b5_flag = 1'b0;
  bit            erase_fail = 1'b0;
  bit            tog = 1'b0;
  int            n_done = 0;

  always @(posedge fl_we_n) begin
    if (rst_n) begin
      if (wl_n < 16) begin
        wl_a[wl_n] = fl_addr;
        wl_d[wl_n] = fl_dq_out;
      end
      wl_n++;
      hist = {hist[39:0], fl_dq_out};
      if (hist[31:8] == 24'hAA55A0) begin
        mem[fl_addr] = mem[fl_addr] & fl_dq_out;
        busy_left = busy_len;
        hist = '0;
      end else if (hist[47:8] == 40'hAA5580AA55 &&
                   (fl_dq_out == 8'h30 || fl_dq_out == 8'h10)) begin
        if (!erase_fail) begin
          for (int i = 0; i < MEMN; i++) begin
            if (fl_dq_out == 8'h10 || (i >> (AW - 3)) == (fl_addr >> (AW - 3)))
              mem[i] = 8'hFF;
          end
        end
        busy_left = busy_len;
        hist = '0;
      end else if (fl_dq_out == 8'hF0) begin
        stuck_mode = 0;
        b5_flag = 1'b0;
        busy_left = 0;
        hist = '0;
      end
    end
  end

  always @(negedge fl_oe_n) begin
    if (rst_n) begin
      rdcnt++;
      if (stuck_mode != 0 || busy_left > 0) begin
        tog = ~tog;
        dq_in_r = {1'b0, tog, (stuck_mode == 1) || b5_flag, 5'b0};
        if (busy_left > 0) busy_left--;
      end else begin
        dq_in_r = mem[fl_addr];
      end
    end
  end

  always @(posedge clk) if (rst_n && done) n_done++;

  // ---------------- write-cycle timing monitor ----------------
  int s_cnt = 0, p_cnt = 0, h_cnt = 0, t_bad = 0, t_wr = 0;
  bit in_wr = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!fl_ce_n && fl_dq_oe) begin
        in_wr = 1'b1;
        if (!fl_we_n)        p_cnt++;
        else if (p_cnt == 0) s_cnt++;
        else                 h_cnt++;
      end else if (in_wr) begin
        t_wr++;
        if (s_cnt != TS || p_cnt != TP || h_cnt != TH) t_bad++;
        in_wr = 1'b0; s_cnt = 0; p_cnt = 0; h_cnt = 0;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int base_len(input int op);
    return (op == 0) ? 4 : (op == 3) ? 1 : 6;
  endfunction

  function automatic logic [19:0] exp_beat(input int op, input int i,
                                           input logic [AW-1:0] a, input logic [7:0] d);
    // returns {addr[11:0], data}
    if (op == 3 || i >= base_len(op)) return {12'h000, 8'hF0};
    case (i)
      0, 3: if (op == 0 && i == 3) return {a, d}; else return {12'h555, 8'hAA};
      1, 4: return {12'h2AA, 8'h55};
      2:    return {12'h555, (op == 0) ? 8'hA0 : 8'h80};
      default: return (op == 1) ? {a, 8'h30} : {12'h555, 8'h10};
    endcase
  endfunction

  function automatic int ref_apply(input int op, input logic [AW-1:0] a, input logic [7:0] d);
    int code;
    code = 0;
    if (op == 0) begin
      if ((ref_mem[a] & d) != d) code = 1;
      ref_mem[a] = ref_mem[a] & d;
    end else if (op == 1 || op == 2) begin
      for (int i = 0; i < MEMN; i++)
        if (op == 2 || (i >> (AW - 3)) == (a >> (AW - 3))) ref_mem[i] = 8'hFF;
    end
    return code;
  endfunction

  task automatic run_op(input int op, input logic [AW-1:0] a, input logic [7:0] d,
                        input int exp_code, input string tag, input bit poke);
    int nd0, bad, len;
    bit got;
    logic [19:0] eb;
    wl_n = 0; rdcnt = 0; nd0 = n_done; got = 1'b0;
    @(negedge clk);
    req_op = op[1:0]; req_addr = a; req_data = d; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    for (int c = 0; c < 4000 && !got; c++) begin
      if (poke && c == 8) begin req_op = 2'd3; req_start = 1'b1; end
      if (poke && c == 9) req_start = 1'b0;
      @(negedge clk);
      if (done) got = 1'b1;
    end
    req_start = 1'b0;
    check(got, tag, "done seen", got, 1);
    check(err_code == exp_code[1:0], tag, "err_code", err_code, exp_code);
    check(err == (exp_code != 0), tag, "err flag (R11)", err, exp_code != 0);
    len = base_len(op) + ((exp_code >= 2) ? 1 : 0);
    check(wl_n == len, tag, "write count", wl_n, len);
    bad = 0;
    for (int i = 0; i < len && i < 16; i++) begin
      eb = exp_beat(op, i, a, d);
      if (wl_a[i] != eb[19:8] || wl_d[i] != eb[7:0]) bad++;
    end
    check(bad == 0, tag, "write sequence mismatches", bad, 0);
    repeat (3) @(negedge clk);
    check(n_done - nd0 == 1, "R11", "done pulses", n_done - nd0, 1);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    int op, code;
    logic [AW-1:0] a;
    logic [7:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < MEMN; i++) begin mem[i] = 8'hFF; ref_mem[i] = 8'hFF; end
    repeat (3) @(negedge clk);
    check(fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe, "R4", "pins idle in reset",
          {fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe}, 4'b1110);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !done, "R11", "idle after reset", {busy, done}, 0);

    // R1 R5 R6: program on a settled device: two status reads then one verify read
    busy_len = 0;
    code = ref_apply(0, 12'h123, 8'h5A);
    run_op(0, 12'h123, 8'h5A, code, "R1", 1'b0);
    check(rdcnt == 3, "R5", "reads for settled device", rdcnt, 3);

    // R6: programming ones over zeros fails verify
    busy_len = 3;
    code = ref_apply(0, 12'h123, 8'hA5);
    run_op(0, 12'h123, 8'hA5, code, "R6", 1'b0);
    check(code == 1, "R6", "mirror expects mismatch", code, 1);

    // R2 R7: sector erase then verify FFh
    code = ref_apply(1, 12'h134, 8'h00);
    run_op(1, 12'h134, 8'h00, code, "R2", 1'b0);
    check(mem[12'h123] == 8'hFF, "R7", "erased byte", mem[12'h123], 8'hFF);

    // R3: chip erase
    busy_len = 5;
    code = ref_apply(2, 12'h777, 8'h00);
    run_op(2, 12'h777, 8'h00, code, "R3", 1'b0);

    // R7: erase that leaves data behind
    busy_len = 1;
    code = ref_apply(0, 12'h200, 8'h00);
    run_op(0, 12'h200, 8'h00, code, "R7", 1'b0);
    erase_fail = 1'b1;
    run_op(1, 12'h200, 8'h00, 1, "R7", 1'b0);
    erase_fail = 1'b0;
    code = ref_apply(1, 12'h200, 8'h00);
    run_op(1, 12'h200, 8'h00, code, "R7", 1'b0);

    // R8: bit 5 with endless toggling -> two extra reads, code 2, reset write
    stuck_mode = 1;
    run_op(0, 12'h300, 8'hFF, 2, "R8", 1'b0);
    check(rdcnt == 4, "R8", "status reads before giving up", rdcnt, 4);

    // R8: bit 5 raised but device settles within the extra reads
    stuck_mode = 0; b5_flag = 1'b1; busy_len = 2;
    code = ref_apply(0, 12'h301, 8'h3C);
    run_op(0, 12'h301, 8'h3C, code, "R8", 1'b0);
    b5_flag = 1'b0;

    // R9: endless toggling without bit 5 -> poll budget
    stuck_mode = 2;
    run_op(0, 12'h302, 8'hFF, 3, "R9", 1'b0);
    check(rdcnt == MP, "R9", "status reads at budget", rdcnt, MP);
    stuck_mode = 0;

    // R12: device reset operation
    run_op(3, 12'h456, 8'h00, 0, "R12", 1'b0);
    check(rdcnt == 0, "R12", "no reads", rdcnt, 0);

    // R10: start during busy is ignored
    busy_len = 2;
    code = ref_apply(0, 12'h010, 8'h81);
    run_op(0, 12'h010, 8'h81, code, "R10", 1'b1);
    repeat (20) @(negedge clk);
    check(!busy && wl_n == 4, "R10", "no extra operation", {busy, wl_n[3:0]}, 4);

    // random mix against the mirror
    for (int k = 0; k < 40; k++) begin
      op = int'($urandom_range(0, 9));
      op = (op < 7) ? 0 : (op < 9) ? 1 : 2;
      a = AW'($urandom);
      d = 8'($urandom);
      busy_len = int'($urandom_range(0, 5));
      code = ref_apply(op, a, d);
      run_op(op, a, d, code, (op == 0) ? "R6" : (op == 1) ? "R2" : "R3", 1'b0);
    end

    check(t_wr > 0 && t_bad == 0, "R4", "write strobe timing violations", t_bad, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule